// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Address and Count Engine

This block is the address and count engine of a single DMA channel. Software programs a memory address, an 8-bit transfer counter with an 8-bit reload value, a control byte and a channel enable through a small register port. Each time the bus side reports a finished transfer, the engine moves the memory address by one or two bytes, up or down, and counts the transfer down.

When the counter runs out in repeat mode, three things happen in the same clock edge. The counter takes its reload value, the address returns to the value software last wrote, and the enable stays on. The channel therefore loops over the same buffer until software turns it off.

With repeat mode off, the channel stops at the end of the count. It clears its own enable and raises a one-cycle completion pulse.

Top module: `dmarpt_channel`

## Requirements
- R1: After reset the control byte reads 0x00, the enable reads 0, the memory address reads 0x0000 and `done_pulse` is 0.
- R2: Each accepted transfer strobe lowers the counter by one. A counter value of 0x00 stands for 256 transfers, so from 0x00 the count wraps to 0xFF and continues.
- R3: Control bit 7 picks the step size: 0 steps the address by 1 and 1 steps it by 2. Control bit 6 picks the direction: 0 adds the step and 1 subtracts it. The address wraps modulo 2^ADDR_W.
- R4: With control bit 5 set, a strobe that finds the counter at 1 loads the counter from the reload byte and returns the address to the start copy. It does not step the address on that strobe. A reload byte of 0x00 again stands for 256 transfers.
- R5: A repeat-mode wrap leaves the enable set.
- R6: With control bit 5 clear, a strobe that finds the counter at 1 steps the address, leaves the counter at 0x00, clears the enable, and drives `done_pulse` high for exactly one cycle.
- R7: Transfer strobes that arrive while the enable is 0 change neither the address nor the counter.
- R8: Writing the address register also loads the start copy that later wraps restore. No other event changes that copy.
- R9: Reset does not clear the counter or the reload byte; their contents survive reset unchanged.
- R10: The register selects are as follows:
  - 0 is the memory address.
  - 1 is the count word, with the counter in bits 7:0 and the reload byte in bits 15:8.
  - 2 is the control byte, with bit 7 the size, bit 6 the direction of the step, bit 5 the repeat enable, bit 4 the transfer direction and bits 3:0 the request source.
  - 3 is the enable, in bit 0.

  Each select reads back what was written, updated by transfer activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_sel` (combinational) |
| xfer_done | input | 1 | One transfer completed on the bus side |
| mem_addr | output | ADDR_W | Current memory address |
| chan_en | output | 1 | Channel enable |
| done_pulse | output | 1 | One-cycle end-of-count pulse in normal mode |
| xfer_wide | output | 1 | Current transfer size (1 = two bytes) |
| xfer_dir | output | 1 | Transfer direction bit from the control byte |
| xfer_src | output | 4 | Request source field from the control byte |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-step counter decrement and the reload on a repeat wrap;
- the restore of the start address;
- the enable surviving a repeat wrap;
- the normal-mode stop with its single-cycle pulse;
- the address holding still when no strobe is accepted.

Only the bench scenarios can show the rest. Those behaviours are:
- the actual address sequences for each size and direction;
- the 256-transfer meaning of a zero count and a zero reload;
- the retention of the count word across reset;
- the register readback.

// File: rtl/dmarpt_pkg.sv
package dmarpt_pkg;

   localparam int unsigned SEL_W  = 2;
   localparam int unsigned CTRL_W = 8;

   typedef enum logic [SEL_W-1:0] {
      SEL_ADDR   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       wide;     // 1: two-byte step
      logic       down;     // 1: subtract step
      logic       rpt;      // 1: reload and loop at count end
      logic       dir;      // transfer direction
      logic [3:0] src;      // request source
   } ctrl_t;

endpackage

// File: rtl/dmarpt_addr_unit.sv
module dmarpt_addr_unit #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              step_en,
   input  logic              wide,
   input  logic              down,
   input  logic              restore,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] start_addr
);

   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] stepped;

   always_comb begin
      step    = wide ? STEP_TWO : STEP_ONE;
      stepped = down ? (addr - step) : (addr + step);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr       <= '0;
         start_addr <= '0;
      end else if (wr_addr) begin
         addr       <= wdata;
         start_addr <= wdata;
      end else if (restore) begin
         addr       <= start_addr;
      end else if (step_en) begin
         addr       <= stepped;
      end
   end

   // R4
   restore_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !wr_addr) |=> (addr == $past(start_addr)));

   // R7
   idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_addr && !restore && !step_en) |=> $stable(addr));

   // R8
   start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_addr |=> $stable(start_addr));

   // R3
   byte_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !restore && !wr_addr && !wide && !down)
      |=> (addr - $past(addr) == STEP_ONE));

endmodule

// File: rtl/dmarpt_count_unit.sv
module dmarpt_count_unit #(
   parameter int unsigned CNT_W        = 8,
   parameter bit          RETAIN_COUNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_cnt,
   input  logic [2*CNT_W-1:0] wdata,
   input  logic               dec_en,
   input  logic               rpt,
   output logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   rld,
   output logic               expire
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] rld_next;

   assign expire = (cnt == CNT_LAST);

   always_comb begin
      cnt_next = cnt;
      rld_next = rld;
      if (wr_cnt) begin
         cnt_next = wdata[CNT_W-1:0];
         rld_next = wdata[2*CNT_W-1:CNT_W];
      end else if (dec_en) begin
         if (expire) cnt_next = rpt ? rld : '0;
         else        cnt_next = cnt - CNT_LAST;
      end
   end

   generate
      if (RETAIN_COUNT) begin : g_retain
         always_ff @(posedge clk) begin
            cnt <= cnt_next;
            rld <= rld_next;
         end
      end else begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
               rld <= '0;
            end else begin
               cnt <= cnt_next;
               rld <= rld_next;
            end
         end
      end
   endgenerate

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !expire && !wr_cnt) |=> (cnt == $past(cnt) - CNT_LAST));

   // R4
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && expire && rpt && !wr_cnt) |=> (cnt == $past(rld)));

   // R7
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_en && !wr_cnt) |=> $stable(cnt));

endmodule

// File: rtl/dmarpt_ctrl_unit.sv
module dmarpt_ctrl_unit
   import dmarpt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              xfer_ok,
   input  logic              expire,
   output ctrl_t             ctrl,
   output logic              en,
   output logic              done
);

   logic stop_now;

   assign stop_now = xfer_ok && expire && !ctrl.rpt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         en   <= 1'b0;
         done <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(wdata);
         if (wr_en)         en <= wdata[0];
         else if (stop_now) en <= 1'b0;
         done <= stop_now;
      end
   end

   // R5
   keep_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && expire && ctrl.rpt && !wr_en) |=> en);

   // R6
   normal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && expire && !ctrl.rpt && !wr_en) |=> (!en && done));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/dmarpt_channel.sv
module dmarpt_channel
   import dmarpt_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned DATA_W       = 16,
   parameter bit          RETAIN_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              xfer_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              chan_en,
   output logic              done_pulse,
   output logic              xfer_wide,
   output logic              xfer_dir,
   output logic [3:0]        xfer_src
);

   localparam int unsigned CW2 = 2 * CNT_W;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("dmarpt_channel: ADDR_W must not exceed DATA_W");
      end
      if (CW2 > DATA_W) begin : g_bad_cnt
         $error("dmarpt_channel: count word wider than DATA_W");
      end
      if (CTRL_W > DATA_W) begin : g_bad_ctrl
         $error("dmarpt_channel: control byte wider than DATA_W");
      end
   endgenerate

   reg_sel_e          sel;
   logic              wr_addr, wr_cnt, wr_ctrl, wr_en;
   logic              xfer_ok, expire, restore, step_en;
   ctrl_t             ctrl;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0]  cnt, rld;

   assign sel     = reg_sel_e'(reg_sel);
   assign wr_addr = reg_wr && (sel == SEL_ADDR);
   assign wr_cnt  = reg_wr && (sel == SEL_COUNT);
   assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
   assign wr_en   = reg_wr && (sel == SEL_ENABLE);

   assign xfer_ok = xfer_done && chan_en;
   assign restore = xfer_ok && expire && ctrl.rpt;
   assign step_en = xfer_ok && !restore;

   dmarpt_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_addr    (wr_addr),
      .wdata      (reg_wdata[ADDR_W-1:0]),
      .step_en    (step_en),
      .wide       (ctrl.wide),
      .down       (ctrl.down),
      .restore    (restore),
      .addr       (mem_addr),
      .start_addr (start_addr)
   );

   dmarpt_count_unit #(.CNT_W(CNT_W), .RETAIN_COUNT(RETAIN_COUNT)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cnt (wr_cnt),
      .wdata  (reg_wdata[CW2-1:0]),
      .dec_en (xfer_ok),
      .rpt    (ctrl.rpt),
      .cnt    (cnt),
      .rld    (rld),
      .expire (expire)
   );

   dmarpt_ctrl_unit u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_en   (wr_en),
      .wdata   (reg_wdata[CTRL_W-1:0]),
      .xfer_ok (xfer_ok),
      .expire  (expire),
      .ctrl    (ctrl),
      .en      (chan_en),
      .done    (done_pulse)
   );

   assign xfer_wide = ctrl.wide;
   assign xfer_dir  = ctrl.dir;
   assign xfer_src  = ctrl.src;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_ADDR:   reg_rdata[ADDR_W-1:0] = mem_addr;
         SEL_COUNT:  reg_rdata[CW2-1:0]    = {rld, cnt};
         SEL_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl;
         SEL_ENABLE: reg_rdata[0]          = chan_en;
         default:    reg_rdata             = '0;
      endcase
   end

   // R8
   start_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_addr |=> (start_addr == mem_addr));

endmodule

// File: tb/tb_dmarpt_channel.sv
module tb_dmarpt_channel;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        xfer_done = 1'b0;
   logic [15:0] mem_addr;
   logic        chan_en, done_pulse, xfer_wide, xfer_dir;
   logic [3:0]  xfer_src;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] addr;
      logic        en;
      logic        done;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [15:0] m_addr, m_start;
   logic [7:0]  m_cnt, m_rld, m_ctrl;
   logic        m_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmarpt_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
      .mem_addr(mem_addr), .chan_en(chan_en), .done_pulse(done_pulse),
      .xfer_wide(xfer_wide), .xfer_dir(xfer_dir), .xfer_src(xfer_src)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      case (sel)
         2'd0: begin m_addr = d; m_start = d; end
         2'd1: begin m_cnt = d[7:0]; m_rld = d[15:8]; end
         2'd2: m_ctrl = d[7:0];
         default: m_en = d[0];
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_check(input logic [1:0] sel, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_sel = sel;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   // driver: predicts the result of one strobe and queues it
   task automatic strobe(input string tag);
      exp_t e;
      logic [15:0] stp;
      logic        fin;
      stp = m_ctrl[7] ? 16'd2 : 16'd1;
      fin = 1'b0;
      if (m_en) begin
         if (m_cnt == 8'd1) begin
            if (m_ctrl[5]) begin
               m_cnt  = m_rld;
               m_addr = m_start;
            end else begin
               m_cnt  = 8'd0;
               m_en   = 1'b0;
               m_addr = m_ctrl[6] ? m_addr - stp : m_addr + stp;
               fin    = 1'b1;
            end
         end else begin
            m_cnt  = m_cnt - 8'd1;
            m_addr = m_ctrl[6] ? m_addr - stp : m_addr + stp;
         end
      end
      e.addr = m_addr; e.en = m_en; e.done = fin; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   // monitor: pops one expected item per strobe edge
   always begin
      @(posedge clk);
      if (xfer_done === 1'b1) begin
         #(CLK_PERIOD/4);
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL monitor: strobe with empty scoreboard");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " addr"}, mem_addr, e.addr);
            check({e.tag, " en"}, {15'd0, chan_en}, {15'd0, e.en});
            check({e.tag, " done"}, {15'd0, done_pulse}, {15'd0, e.done});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_addr = '0; m_start = '0; m_cnt = '0; m_rld = '0; m_ctrl = '0; m_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_check(2'd2, 16'h0000, "R1 ctrl");
      reg_check(2'd3, 16'h0000, "R1 enable");
      reg_check(2'd0, 16'h0000, "R1 addr");
      check("R1 done", {15'd0, done_pulse}, 16'h0000);

      // R10 readback
      reg_write(2'd2, 16'h00AB);
      reg_check(2'd2, 16'h00AB, "R10 ctrl");
      check("R10 src pins", {12'd0, xfer_src}, 16'h000B);
      reg_write(2'd1, 16'h5A21);
      reg_check(2'd1, 16'h5A21, "R10 count word");

      // R6 normal mode, byte up (R3)
      reg_write(2'd2, 16'h0000);
      reg_write(2'd0, 16'h1000);
      reg_write(2'd1, 16'h0003);
      reg_write(2'd3, 16'h0001);
      strobe("R3 byte up 1");
      strobe("R2 byte up 2");
      strobe("R6 last");
      @(posedge clk); #1;
      check("R6 done one cycle", {15'd0, done_pulse}, 16'h0000);
      reg_check(2'd1, 16'h0000, "R6 count at end");
      strobe("R7 ignored");
      reg_check(2'd1, 16'h0000, "R7 count unchanged");

      // R3 word up, normal mode
      reg_write(2'd2, 16'h0080);
      reg_write(2'd0, 16'hFFFE);
      reg_write(2'd1, 16'h0002);
      reg_write(2'd3, 16'h0001);
      strobe("R3 word up wrap");
      strobe("R6 word end");

      // R4/R5 repeat mode, word down
      reg_write(2'd2, 16'h00E0);
      reg_write(2'd0, 16'h2000);
      reg_write(2'd1, 16'h0302);
      reg_write(2'd3, 16'h0001);
      strobe("R3 word down");
      strobe("R4 wrap 1");
      reg_check(2'd1, 16'h0303, "R4 reload");
      reg_check(2'd3, 16'h0001, "R5 enable kept");
      strobe("R3 word down again");
      strobe("R2 second lap");
      strobe("R4 wrap 2");
      reg_check(2'd0, 16'h2000, "R8 start restored");

      // R2/R4 zero count means 256, repeat, byte up
      reg_write(2'd2, 16'h0020);
      reg_write(2'd0, 16'h0040);
      reg_write(2'd1, 16'h0000);
      reg_write(2'd3, 16'h0001);
      for (int i = 0; i < 256; i++) strobe("R2 256 loop");
      reg_check(2'd1, 16'h0000, "R4 zero reload");
      reg_check(2'd0, 16'h0040, "R4 addr after 256");
      strobe("R4 next lap");
      reg_check(2'd1, 16'h00FF, "R2 zero as 256");

      // R7 software stop
      reg_write(2'd3, 16'h0000);
      strobe("R7 after stop");
      reg_check(2'd1, 16'h00FF, "R7 count held");

      // R9 count word survives reset
      reg_write(2'd1, 16'h7C19);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      m_ctrl = '0; m_en = 1'b0; m_addr = '0; m_start = '0;
      reg_check(2'd1, 16'h7C19, "R9 retained");
      reg_check(2'd2, 16'h0000, "R1 ctrl after reset");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule